// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the slave end of a two-wire serial bus in front of a 2048-byte memory. It oversamples the clock line and the data line with the system clock. It finds bus start and stop events and checks the four-bit device code. It then builds an 11-bit byte address from two fields: the low bits of the device byte and a following address byte. It pulls the data line low to acknowledge and to send read data. The data line is open-drain, so the block only ever pulls it low or lets it go.

A write collects up to sixteen bytes in a page buffer. The stop event starts a timed write period. For `WR_CYCLES` system clocks the block does not respond on the bus. At the end of that period every buffered byte is copied into the array in one step. Reads return bytes from an address pointer that runs through the whole array and wraps. The read continues for as long as the master acknowledges. A lockout input makes a stop event drop the pending write.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_pull` = 0). It stays idle until a start event: data falling while the clock is high. A stop event is data rising while the clock is high.
- R2: The slave acknowledges a device byte only when its bits 7:4 equal 1010. Any other code is not acknowledged. The bus is then ignored until the next start event.
- R3: For a write, device-byte bits 3:1 give address bits 10:8. The next byte gives address bits 7:0. A single data byte then stored reads back unchanged at that address.
- R4: During a write the slave pulls the data line low in the ninth clock of the device byte, of the address byte and of every data byte.
- R5: In a page write, only address bits 3:0 advance after each data byte, and they wrap from 15 to 0. Address bits 10:4 never change, and a later byte sent to the same offset replaces an earlier one.
- R6: The stop event that ends a write with data starts a write period of `WR_CYCLES` clocks. During that period the data line is never pulled, so a device byte gets no acknowledge. The data is visible after the period.
- R7: Read bytes go out most significant bit first, and the data line changes only while the clock is low. A read sent right after a write header plus a repeated start returns the byte at the address just set. A read with no preceding write header returns the byte after the last byte read.
- R8: While the master acknowledges, the slave sends further bytes from the next addresses. The address goes from 2047 to 0.
- R9: When the master does not acknowledge a read byte, the slave releases the data line. It ignores further clocks until a start or stop event.
- R10: If `wr_lock` is high at the stop event, the buffered write is dropped. No write period starts, and the memory keeps its old contents.
- R11: A repeated start at any point restarts device-byte decoding and drops any data not yet written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the wired bus |
| wr_lock | input | 1 | When high at a stop event, the pending write is dropped |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest case to reach is a page write that goes past sixteen bytes. It has to end in a single commit, and only that commit shows the wrap and the overwrite. The stimulus sends eighteen bytes from offset 3 of a page and waits out the write period. It then reads the whole page back in one sequential read and also reads the bytes just outside the page. A second hard case is the read pointer passing from 2047 to 0. The bench reaches it by first writing bytes at the two top addresses and at address 0, then doing one sequential read that starts at 2046.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_lock,
  output logic sda_pull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA, S_BUSY} st_t;

  logic [2:0] scl_q, sda_q;
  logic       scl_s, scl_d, sda_s, sda_d;
  logic       start_c, stop_c, scl_rise, scl_fall;

  st_t               st;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] addr;
  logic [PAGE-1:0]   vmask;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];
  logic              mack, first;
  logic [CW-1:0]     bcnt;
  logic              commit;

  assign scl_s    = scl_q[1];
  assign scl_d    = scl_q[2];
  assign sda_s    = sda_q[1];
  assign sda_d    = sda_q[2];
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign commit   = (st == S_BUSY) && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; addr <= '0;
      vmask <= '0; mack <= 1'b0; first <= 1'b0; bcnt <= '0; sda_pull <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (st == S_BUSY) begin
      sda_pull <= 1'b0;
      if (bcnt == '0) st <= S_IDLE;
      else bcnt <= bcnt - CW'(1);
    end else if (start_c) begin
      st <= S_DEV; cnt <= '0; sda_pull <= 1'b0; vmask <= '0;
    end else if (stop_c) begin
      sda_pull <= 1'b0;
      if (st == S_WDATA && (|vmask) && !wr_lock) begin
        st   <= S_BUSY;
        bcnt <= CW'(WR_CYCLES - 1);
      end else begin
        st <= S_IDLE;
      end
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (cnt == 4'd8) mack <= ~sda_s;
        cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            S_DEV: begin
              if (sh[7:4] == DEV_CODE) begin
                sda_pull <= 1'b1;
                if (sh[0]) begin
                  st <= S_RDATA; first <= 1'b1;
                end else begin
                  st <= S_ADDR; addr[ADDR_W-1:8] <= sh[HI_W:1];
                end
              end else begin
                st <= S_IDLE;
              end
            end
            S_ADDR: begin
              sda_pull <= 1'b1; addr[7:0] <= sh; st <= S_WDATA;
            end
            S_WDATA: begin
              sda_pull <= 1'b1;
              pbuf[addr[PAGE_W-1:0]]  <= sh;
              vmask[addr[PAGE_W-1:0]] <= 1'b1;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          sda_pull <= 1'b0;
          if (st == S_RDATA) begin
            if (first || mack) begin
              tx <= mem[addr]; sda_pull <= ~mem[addr][7];
              addr <= addr + ADDR_W'(1); first <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
        end else if (st == S_RDATA && cnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0};
          sda_pull <= ~tx[6];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (vmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull); // R2
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> !sda_pull); // R6
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R7
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA && $past(st) == S_WDATA) |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])); // R5
  AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA && stop_c && wr_lock) |=> st != S_BUSY); // R10
  AST_RESTART_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_BUSY && start_c) |=> (st == S_DEV && vmask == '0)); // R11
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int WRC = 2000;
  localparam int NV  = 7;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h11}, {11'h055, 8'h3C}, {11'h130, 8'h5A}, {11'h200, 8'hC3},
    {11'h7FF, 8'h99}, {11'h11F, 8'h81}, {11'h7FE, 8'h42}};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WRC)) u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .wr_lock(wr_lock), .sda_pull(sda_pull));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wq(); repeat (10) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bstop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_bus; scl_m = 0; wq();
  endtask

  task automatic recv(output logic [7:0] b, input bit mack);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1; wq(); b = {b[6:0], sda_bus}; scl_m = 0;
    end
    wq(); sda_m = ~mack; wq(); scl_m = 1; wq(); scl_m = 0; wq(); sda_m = 1;
  endtask

  task automatic set_ptr(input logic [10:0] a, output bit ok);
    bit k0, k1;
    bstart(); send({4'hA, a[10:8], 1'b0}, k0); send(a[7:0], k1);
    ok = k0 & k1;
  endtask

  task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
    bit ok, k;
    set_ptr(a, ok); bstart(); send(8'hA1, k); recv(d, 1'b0); bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    bit ok, k, k2;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 idle after reset", sda_pull, 0);

    for (int v = 0; v < NV; v++) begin
      set_ptr(VEC[v][18:8], ok); send(VEC[v][7:0], k); bstop();
      chk(ok & k, "R4 write acks", {ok, k}, 3);
      bstart(); send(8'hA0, k2); bstop();
      chk(!k2, "R6 busy no ack", k2, 0);
      repeat (WRC + 20) @(negedge clk);
      rand_read(VEC[v][18:8], d);
      chk(d == VEC[v][7:0], "R3 byte readback", d, VEC[v][7:0]);
    end

    bstart(); send(8'hB0, k); chk(!k, "R2 wrong code nack", k, 0);
    send(8'h00, k); chk(!k, "R2 ignored after mismatch", k, 0);
    bstop();

    rand_read(11'h7FE, d); chk(d == 8'h42, "R7 random read", d, 8'h42);
    bstart(); send(8'hA1, k); recv(d, 1'b0); bstop();
    chk(d == 8'h99, "R7 current address read", d, 8'h99);

    set_ptr(11'h7FE, ok); bstart(); send(8'hA1, k);
    recv(d, 1'b1); chk(d == 8'h42, "R8 seq byte 0", d, 8'h42);
    recv(d, 1'b1); chk(d == 8'h99, "R8 seq byte 1", d, 8'h99);
    recv(d, 1'b0); chk(d == 8'h11, "R8 wrap to 0", d, 8'h11);
    bstop();

    set_ptr(11'h055, ok); bstart(); send(8'hA1, k);
    recv(d, 1'b0); chk(d == 8'h3C, "R9 last byte", d, 8'h3C);
    recv(d, 1'b0); chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    bstop();

    wr_lock = 1'b1;
    set_ptr(11'h055, ok); send(8'hEE, k); bstop();
    wr_lock = 1'b0;
    bstart(); send(8'hA0, k); bstop();
    chk(k, "R10 no write period", k, 1);
    rand_read(11'h055, d); chk(d == 8'h3C, "R10 memory kept", d, 8'h3C);

    set_ptr(11'h200, ok); send(8'h77, k);
    set_ptr(11'h200, ok); bstart(); send(8'hA1, k);
    recv(d, 1'b0); bstop();
    chk(d == 8'hC3, "R11 restart read", d, 8'hC3);
    bstart(); send(8'hA0, k); bstop();
    chk(k, "R11 buffer dropped", k, 1);
    rand_read(11'h200, d); chk(d == 8'hC3, "R11 memory kept", d, 8'hC3);

    set_ptr(11'h123, ok);
    k2 = 1'b1;
    for (int j = 0; j < 18; j++) begin
      send(8'h40 + 8'(j), k); k2 &= k;
    end
    bstop();
    chk(ok & k2, "R4 page acks", {ok, k2}, 3);
    repeat (WRC + 20) @(negedge clk);
    set_ptr(11'h120, ok); bstart(); send(8'hA1, k);
    for (int o = 0; o < 16; o++) begin
      int kk;
      kk = (o + 13) % 16;
      if (kk < 2) kk += 16;
      recv(d, o != 15);
      chk(d == 8'(8'h40 + kk), "R5 page wrap", d, 8'h40 + kk);
    end
    bstop();
    rand_read(11'h130, d); chk(d == 8'h5A, "R5 next page intact", d, 8'h5A);
    rand_read(11'h11F, d); chk(d == 8'h81, "R5 prev page intact", d, 8'h81);

    finish_run();
  end
endmodule